// File: doc/BRIEF.md
# Byte-Serial Carry-Chained Multi-Byte Adder

This block adds two unsigned integers of arbitrary byte length that sit in a byte-wide memory, least significant byte at the lowest address. It has one 8-bit adder and one carry flag. A pulse on the start input captures three 16-bit base addresses (first addend, second addend, result) and a byte count. The block then steps an index from zero upward. For each index it reads one byte from each addend, adds the two bytes and the carry, writes the low byte of the sum to the result array and keeps the carry for the next index.

The block is the only master on a single-port synchronous memory. A read returns its data one cycle after the request. The precision of the addition comes from the byte count given at run time, so the same hardware handles a 1-byte add or a 255-byte add. When the last result byte has been written, a one-cycle done pulse is raised. The carry out of the most significant byte stays on the carry output until the next run starts.

In the usual layout the three arrays are contiguous: the second addend starts at the first base plus the count, and the result starts at the second base plus the count. Any three bases are accepted.

Top module: `byte_chain_adder`

## Requirements
- R1: `start_i` is accepted only when the block is idle. Acceptance clears the carry to 0, sets the index to 0, and captures the three bases and the count. Changes on those inputs after acceptance have no effect on the run in progress.
- R2: Each result byte equals (A[i] + B[i] + carry_in) mod 256. The carry_in of byte 0 is 0, and the carry_in of byte i+1 is bit 8 of the sum at byte i.
- R3: Byte i of each array is accessed at address base + i, modulo 65536. Index 0 is processed first and the index rises by one per byte.
- R4: Each byte takes three consecutive one-cycle transactions in this order: read A[i], read B[i], write C[i]. The first read is issued in the cycle after start is accepted. Read data is taken from `mem_rdata_i` in the cycle after the read request. Read and write are never requested in the same cycle.
- R5: A run with count N > 0 performs exactly N writes. `done_o` is high in the cycle right after the write of byte N-1.
- R6: `done_o` is high for exactly one cycle per run.
- R7: After done, `carry_o` holds the carry out of the most significant byte and keeps it until the next accepted start.
- R8: With a count of 0, `done_o` is high in the cycle after start is accepted, no memory transaction is made, and `carry_o` is 0.
- R9: `start_i` has no effect while a run is in progress or during the done cycle.
- R10: While reset is high, and in the first idle cycles after it, `done_o`, `carry_o`, `mem_rd_o` and `mem_wr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (taken only when idle) |
| base_a_i | input | 16 | Base address of the first addend |
| base_b_i | input | 16 | Base address of the second addend |
| base_c_i | input | 16 | Base address of the result |
| size_i | input | 8 | Operand length in bytes |
| done_o | output | 1 | One-cycle end-of-run pulse |
| carry_o | output | 1 | Carry flag; final carry out after done |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after a read request |

## Verification
The bench builds the block with its default parameters: 16-bit addresses, 8-bit data and an 8-bit count. This makes a count of 255 reachable, where the index climbs to its largest value and the stop compare is exercised at full width. It also makes base addresses near 0xFFFF reachable, so the array addresses wrap around to page zero. Carry chains that ripple through every byte, a count of zero, and start held high through a run while the bases change are all covered with these settings.

// File: rtl/bca_pkg.sv
package bca_pkg;

    localparam int BCA_ADDR_W  = 16;
    localparam int BCA_DATA_W  = 8;
    localparam int BCA_SIZE_W  = 8;
    localparam int BCA_NUM_OPR = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RDA,
        ST_RDB,
        ST_WRC,
        ST_FIN
    } bca_state_e;

    typedef enum logic [1:0] {
        OPR_A = 2'd0,
        OPR_B = 2'd1,
        OPR_C = 2'd2
    } bca_opr_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        bca_opr_e sel;
        logic     idx_clr;
        logic     idx_inc;
        logic     cap_a;
        logic     sum_en;
        logic     carry_clr;
    } bca_ctrl_t;

    function automatic logic is_last(input logic [BCA_SIZE_W-1:0] idx,
                                     input logic [BCA_SIZE_W-1:0] count);
        logic [BCA_SIZE_W:0] nxt;
        nxt = {1'b0, idx} + {{BCA_SIZE_W{1'b0}}, 1'b1};
        return nxt == {1'b0, count};
    endfunction

endpackage

// File: rtl/bca_ctrl.sv
module bca_ctrl
    import bca_pkg::*;
#(
    parameter int SIZE_W = BCA_SIZE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [SIZE_W-1:0] idx_i,
    output bca_ctrl_t         ctrl_o,
    output logic              done_o
);

    bca_state_e        st_q;
    bca_state_e        st_d;
    logic [SIZE_W-1:0] size_q;
    logic              last;

    assign last = is_last(BCA_SIZE_W'(idx_i), BCA_SIZE_W'(size_q));

    always_comb begin
        ctrl_o = '0;
        st_d   = st_q;
        case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    ctrl_o.idx_clr   = 1'b1;
                    ctrl_o.carry_clr = 1'b1;
                    st_d = (size_i == '0) ? ST_FIN : ST_RDA;
                end
            end
            ST_RDA: begin
                ctrl_o.rd  = 1'b1;
                ctrl_o.sel = OPR_A;
                st_d       = ST_RDB;
            end
            ST_RDB: begin
                ctrl_o.rd    = 1'b1;
                ctrl_o.sel   = OPR_B;
                ctrl_o.cap_a = 1'b1;
                st_d         = ST_WRC;
            end
            ST_WRC: begin
                ctrl_o.wr      = 1'b1;
                ctrl_o.sel     = OPR_C;
                ctrl_o.sum_en  = 1'b1;
                ctrl_o.idx_inc = 1'b1;
                st_d           = last ? ST_FIN : ST_RDA;
            end
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            size_q <= '0;
        end else begin
            st_q <= st_d;
            if (ctrl_o.idx_clr) size_q <= size_i;
        end
    end

    assign done_o = (st_q == ST_FIN);

endmodule

// File: rtl/bca_agen.sv
module bca_agen
    import bca_pkg::*;
#(
    parameter int ADDR_W = BCA_ADDR_W,
    parameter int IDX_W  = BCA_SIZE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bca_ctrl_t         ctrl_i,
    input  logic [ADDR_W-1:0] base_a_i,
    input  logic [ADDR_W-1:0] base_b_i,
    input  logic [ADDR_W-1:0] base_c_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int NOPR = BCA_NUM_OPR;

    logic [ADDR_W-1:0] base_in [NOPR];
    logic [ADDR_W-1:0] base_q  [NOPR];
    logic [ADDR_W-1:0] addr_k  [NOPR];
    logic [IDX_W-1:0]  idx_q;

    assign base_in[0] = base_a_i;
    assign base_in[1] = base_b_i;
    assign base_in[2] = base_c_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NOPR; k++) base_q[k] <= '0;
            idx_q <= '0;
        end else begin
            if (ctrl_i.idx_clr) begin
                for (int k = 0; k < NOPR; k++) base_q[k] <= base_in[k];
                idx_q <= '0;
            end else if (ctrl_i.idx_inc) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    for (genvar k = 0; k < NOPR; k++) begin : g_opr
        assign addr_k[k] = base_q[k] + ADDR_W'(idx_q);
    end

    always_comb begin
        case (ctrl_i.sel)
            OPR_B:   addr_o = addr_k[1];
            OPR_C:   addr_o = addr_k[2];
            default: addr_o = addr_k[0];
        endcase
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/bca_alu.sv
module bca_alu
    import bca_pkg::*;
#(
    parameter int DATA_W = BCA_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  bca_ctrl_t         ctrl_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic              carry_o
);

    logic [DATA_W-1:0] a_q;
    logic              cy_q;
    logic [DATA_W:0]   sum;

    assign sum = {1'b0, a_q} + {1'b0, rdata_i} + {{DATA_W{1'b0}}, cy_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q  <= '0;
            cy_q <= 1'b0;
        end else begin
            if (ctrl_i.cap_a) a_q <= rdata_i;
            if (ctrl_i.carry_clr)   cy_q <= 1'b0;
            else if (ctrl_i.sum_en) cy_q <= sum[DATA_W];
        end
    end

    assign wdata_o = sum[DATA_W-1:0];
    assign carry_o = cy_q;

endmodule

// File: rtl/byte_chain_adder.sv
module byte_chain_adder
    import bca_pkg::*;
#(
    parameter int ADDR_W = BCA_ADDR_W,
    parameter int DATA_W = BCA_DATA_W,
    parameter int SIZE_W = BCA_SIZE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_a_i,
    input  logic [ADDR_W-1:0] base_b_i,
    input  logic [ADDR_W-1:0] base_c_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic              done_o,
    output logic              carry_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    bca_ctrl_t         ctrl;
    logic [SIZE_W-1:0] idx;

    bca_ctrl #(.SIZE_W(SIZE_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .size_i  (size_i),
        .idx_i   (idx),
        .ctrl_o  (ctrl),
        .done_o  (done_o)
    );

    bca_agen #(.ADDR_W(ADDR_W), .IDX_W(SIZE_W)) u_agen (
        .clk      (clk),
        .rst      (rst),
        .ctrl_i   (ctrl),
        .base_a_i (base_a_i),
        .base_b_i (base_b_i),
        .base_c_i (base_c_i),
        .idx_o    (idx),
        .addr_o   (mem_addr_o)
    );

    bca_alu #(.DATA_W(DATA_W)) u_alu (
        .clk     (clk),
        .rst     (rst),
        .ctrl_i  (ctrl),
        .rdata_i (mem_rdata_i),
        .wdata_o (mem_wdata_o),
        .carry_o (carry_o)
    );

    assign mem_rd_o = ctrl.rd;
    assign mem_wr_o = ctrl.wr;

endmodule

// File: rtl/bca_chk.sv
module bca_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              done_o,
    input logic              carry_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic [DATA_W-1:0] mem_rdata_i
);

    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W:0]   exp_sum;

    always_ff @(posedge clk) begin
        if (rst) rdata_d <= '0;
        else     rdata_d <= mem_rdata_i;
    end

    assign exp_sum = {1'b0, rdata_d} + {1'b0, mem_rdata_i} + {{DATA_W{1'b0}}, carry_o};

    AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o)); // R4

    AST_WRITE_AFTER_READS: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |-> ($past(mem_rd_o) && $past(mem_rd_o, 2))); // R4

    AST_SUM_BYTE: assert property (@(posedge clk) disable iff (rst)
        mem_wr_o |-> (mem_wdata_o == exp_sum[DATA_W-1:0])); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_o && $past(mem_wr_o, 3)) |-> (mem_addr_o == $past(mem_addr_o, 3) + 1'b1)); // R3

    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!mem_wr_o && !start_i) |=> $stable(carry_o)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R6

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(mem_wr_o) || $past(start_i))); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!mem_rd_o && !mem_wr_o)); // R8

endmodule

bind byte_chain_adder bca_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .done_o      (done_o),
    .carry_o     (carry_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
);

// File: tb/byte_chain_adder_bench.sv
module byte_chain_adder_bench;

    localparam int AW = 16;
    localparam int DW = 8;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_a_i = '0, base_b_i = '0, base_c_i = '0;
    logic [SW-1:0] size_i = '0;
    logic          done_o, carry_o, mem_rd_o, mem_wr_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i = '0;

    always #5 clk = ~clk;

    byte_chain_adder u_byte_chain_adder (
        .clk(clk), .rst(rst), .start_i(start_i),
        .base_a_i(base_a_i), .base_b_i(base_b_i), .base_c_i(base_c_i),
        .size_i(size_i), .done_o(done_o), .carry_o(carry_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    logic [7:0] mem [0:65535];

    always @(posedge clk) begin
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
        if (mem_wr_o) mem[mem_addr_o] <= mem_wdata_o;
    end

    typedef struct {
        bit          rd;
        bit          wr;
        bit          dn;
        logic [15:0] addr;
        logic [7:0]  data;
        string       tag;
    } exp_t;

    exp_t q[$];
    bit   model_carry = 1'b0;
    bit   in_fin = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   ended = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(mem_rd_o == e.rd, e.tag, "read request", int'(mem_rd_o), int'(e.rd));
            check(mem_wr_o == e.wr, e.tag, "write request", int'(mem_wr_o), int'(e.wr));
            check(done_o == e.dn, e.dn ? "R5" : e.tag, "done", int'(done_o), int'(e.dn));
            if (e.rd || e.wr)
                check(mem_addr_o == e.addr, "R3", "address", int'(mem_addr_o), int'(e.addr));
            if (e.wr)
                check(mem_wdata_o == e.data, "R2", "write data", int'(mem_wdata_o), int'(e.data));
            if (e.dn)
                check(carry_o == model_carry, "R7", "final carry", int'(carry_o), int'(model_carry));
            in_fin = e.dn;
        end else begin
            check(!mem_rd_o && !mem_wr_o, rst ? "R10" : "R9", "idle access",
                  int'({mem_rd_o, mem_wr_o}), 0);
            check(!done_o, "R6", "done while idle", int'(done_o), 0);
            check(carry_o == model_carry, rst ? "R10" : "R7", "held carry",
                  int'(carry_o), int'(model_carry));
            in_fin = 1'b0;
        end
    endtask

    task automatic enqueue(input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] c, input int sz);
        bit cy;
        cy = 1'b0;
        for (int i = 0; i < sz; i++) begin
            logic [15:0] aa, bb, cc;
            int s;
            aa = a + 16'(i);
            bb = b + 16'(i);
            cc = c + 16'(i);
            s = int'(mem[aa]) + int'(mem[bb]) + int'(cy);
            q.push_back('{rd: 1, wr: 0, dn: 0, addr: aa, data: 8'h00, tag: "R4"});
            q.push_back('{rd: 1, wr: 0, dn: 0, addr: bb, data: 8'h00, tag: "R4"});
            q.push_back('{rd: 0, wr: 1, dn: 0, addr: cc, data: s[7:0], tag: "R2"});
            cy = s[8];
        end
        q.push_back('{rd: 0, wr: 0, dn: 1, addr: 16'h0, data: 8'h00,
                      tag: (sz == 0) ? "R8" : "R5"});
        model_carry = cy; // R1 clears carry; R8 leaves it 0 for size 0
    endtask

    task automatic tick(input bit st, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] c, input logic [7:0] sz);
        @(negedge clk);
        compare();
        start_i  = st;
        base_a_i = a;
        base_b_i = b;
        base_c_i = c;
        size_i   = sz;
        if (st && !rst && q.size() == 0 && !in_fin) enqueue(a, b, c, int'(sz));
    endtask

    // hold=1 keeps start high through the run and moves the bases (R1, R9)
    task automatic run(input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] c, input logic [7:0] sz, input bit hold);
        tick(1'b1, a, b, c, sz);
        while (q.size() > 0)
            tick(hold, hold ? a + 16'h0100 : a, hold ? b + 16'h0200 : b,
                 hold ? c + 16'h0300 : c, hold ? sz + 8'd1 : sz);
        tick(1'b0, a, b, c, sz);
        tick(1'b0, a, b, c, sz);
        tick(1'b0, a, b, c, sz);
    endtask

    initial begin
        logic [31:0] lcg;
        lcg = 32'h1234_5678;
        for (int i = 0; i < 65536; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            mem[i] = lcg[23:16];
        end
        // R10: reset state
        repeat (3) tick(1'b0, 16'h0, 16'h0, 16'h0, 8'd0);
        rst = 1'b0;
        repeat (2) tick(1'b0, 16'h0, 16'h0, 16'h0, 8'd0);

        // R2/R7: full ripple carry out of top byte
        for (int i = 0; i < 4; i++) begin
            mem[16'h1234 + i] = 8'hFF;
            mem[16'h1238 + i] = (i == 0) ? 8'h01 : 8'h00;
        end
        run(16'h1234, 16'h1238, 16'h123C, 8'd4, 1'b0);
        check(mem[16'h123F] == 8'h00, "R2", "top result byte", int'(mem[16'h123F]), 0);
        check(carry_o == 1'b1, "R7", "carry after ripple", int'(carry_o), 1);

        // R8: size zero, carry forced back to 0
        run(16'h2000, 16'h2000, 16'h2000, 8'd0, 1'b0);

        // R5: single byte
        mem[16'h3000] = 8'h80; mem[16'h3001] = 8'h80;
        run(16'h3000, 16'h3001, 16'h3002, 8'd1, 1'b0);

        // R1/R9: start held high, bases and size moving mid-run
        run(16'h4000, 16'h4008, 16'h4010, 8'd8, 1'b1);

        // R3: addresses wrap through 0xFFFF
        run(16'hFFFE, 16'h0001, 16'h0004, 8'd3, 1'b0);

        // R5: largest count
        run(16'h5000, 16'h50FF, 16'h51FE, 8'd255, 1'b0);

        // contiguous pattern, several lengths
        for (int n = 2; n < 7; n++)
            run(16'h6000, 16'h6000 + 16'(n), 16'h6000 + 16'(2 * n), 8'(n), 1'b0);

        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule